// File: doc/BRIEF.md
# Indexed Configuration Port with Logical-Device Banking

This block is the configuration front end of a multi-function I/O controller. It takes up two consecutive byte addresses on the host I/O bus. The host writes a register index to the lower address (the index port). It then reads or writes the chosen register through the upper address (the data port). A strap input decides whether the pair decodes at 0x2E/0x2F or at 0x4E/0x4F.

Global registers return a fixed chip identifier and a revision byte. They also hold a logical-device number that selects one of fifteen register banks. Each bank holds an activate bit and a 16-bit I/O base address. The bank contents drive per-device outputs, and the function units use these outputs to enable themselves and to decode their own I/O windows.

Indices 0xF0 and above belong to the selected device. An access there produces a single-cycle forwarding strobe. On a read, the selected device returns data on a combinational path.

Top module: `cfg_index_port`

## Requirements
- R1: The port decodes only at base and base+1, where base is 0x2E when `strap_alt`=0 and 0x4E when `strap_alt`=1. Accesses at any other address change no state, and a read there returns 0x00. `bus_rdata` is 0x00 whenever `bus_rd` is low.
- R2: A write at base latches `bus_wdata` as the current index on the next clock edge. A read at base returns the latched index.
- R3: Reading index 0x20 at base+1 returns 0xE9. Writes to index 0x20 have no effect.
- R4: Reading index 0x27 at base+1 returns the revision parameter (default 0x03). Writes to index 0x27 have no effect.
- R5: Index 0x07 holds the logical-device number, which reads back as written. A write of a value above 0x0E is ignored and the previous number is kept.
- R6: Index 0x30 is banked by logical-device number. A write stores `bus_wdata` bit 0 as that device's activate bit and discards bits 7:1. A read returns the activate bit in bit 0 with zeros in bits 7:1.
- R7: Indices 0x60 and 0x61 are banked by logical-device number. They hold bits 15:8 and bits 7:0 of that device's I/O base address and read back as written.
- R8: `dev_active[n]` is device n's activate bit. `dev_base[16n+15:16n]` is device n's base address. Both update on the clock edge that ends the write.
- R9: A data-port access with index ≥ 0xF0 asserts `ext_stb` in that same cycle, with `ext_dev` = logical-device number, `ext_idx` = index, `ext_we` = 1 for a write and 0 for a read, and `ext_wdata` = `bus_wdata`. A read returns `ext_rdata`. `ext_stb` is low at all other times.
- R10: Reading an unimplemented index below 0xF0 returns 0x00. Writing one has no effect.
- R11: After reset, the index is 0x00, the logical-device number is 0x00, every activate bit is 0 and every base address is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_alt | input | 1 | Base select: 0 gives 0x2E, 1 gives 0x4E |
| bus_addr | input | 16 | Host I/O address |
| bus_wr | input | 1 | Single-cycle write pulse |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data, combinational |
| dev_active | output | 15 | Activate bit for each logical device |
| dev_base | output | 240 | 16-bit I/O base for each device, device n at bits 16n+15:16n |
| ext_stb | output | 1 | Device-specific access strobe |
| ext_we | output | 1 | Direction of the forwarded access, 1 = write |
| ext_dev | output | 4 | Logical-device number of the forwarded access |
| ext_idx | output | 8 | Index of the forwarded access |
| ext_wdata | output | 8 | Write data of the forwarded access |
| ext_rdata | input | 8 | Read data from the selected device |

## Verification
The hardest state to reach is a bank other than device 0 that holds non-zero contents while another bank is checked untouched. Reaching it takes a full index, number, index, data sequence, and it must survive a rejected out-of-range device number. The stimulus table does exactly this:
- It selects device 5 and programs its activate bit and base address.
- It tries to select device 0x0F, which must be ignored.
- It moves to device 0x0E and reads that bank back as empty.

Directed steps then flip the strap in the middle of the run. They show that the old address pair goes silent while the latched index carries over.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_CHIP_ID = 8'h20;
    localparam logic [7:0] IDX_REV     = 8'h27;
    localparam logic [7:0] IDX_ACT     = 8'h30;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;
    localparam logic [7:0] IDX_EXT_MIN = 8'hF0;

    localparam logic [7:0] CHIP_ID_VAL = 8'hE9;

    // Decoded host access to the two-byte port
    typedef struct packed {
        logic idx_wr;
        logic idx_rd;
        logic dat_wr;
        logic dat_rd;
    } port_acc_t;

    // Per-device bank contents
    typedef struct packed {
        logic        act;
        logic [15:0] base;
    } bank_t;

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
    import cfg_port_pkg::*;
#(
    parameter int               ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE_PRI = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_ALT = 16'h004E
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              strap_alt,
    input  logic              rd,
    input  logic              wr,
    output port_acc_t         acc
);

    logic [ADDR_W-1:0] base;
    logic              hit_idx;
    logic              hit_dat;

    always_comb begin
        base    = strap_alt ? BASE_ALT : BASE_PRI;
        hit_idx = (addr == base);
        hit_dat = (addr == (base + ADDR_W'(1)));

        acc        = '0;
        acc.idx_wr = hit_idx & wr;
        acc.idx_rd = hit_idx & rd;
        acc.dat_wr = hit_dat & wr;
        acc.dat_rd = hit_dat & rd;
    end

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
    import cfg_port_pkg::*;
#(
    parameter int NUM_DEV = 15,
    parameter int LDN_W   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LDN_W-1:0]      sel,
    input  logic                  wr_act,
    input  logic                  wr_hi,
    input  logic                  wr_lo,
    input  logic [7:0]            wdata,
    output logic [NUM_DEV-1:0]    act,
    output logic [NUM_DEV*16-1:0] base,
    output logic                  sel_act,
    output logic [15:0]           sel_base
);

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
        bank_t b_d;
        bank_t b_q;
        logic  mine;

        always_comb begin
            mine = (sel == LDN_W'(g));
            b_d  = b_q;
            if (mine && wr_act) b_d.act        = wdata[0];
            if (mine && wr_hi)  b_d.base[15:8] = wdata;
            if (mine && wr_lo)  b_d.base[7:0]  = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) b_q <= '0;
            else        b_q <= b_d;
        end

        assign act[g]           = b_q.act;
        assign base[g*16 +: 16] = b_q.base;
    end

    // Read view of the selected bank
    always_comb begin
        sel_act  = 1'b0;
        sel_base = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (sel == LDN_W'(i)) begin
                sel_act  = act[i];
                sel_base = base[i*16 +: 16];
            end
        end
    end

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_port_pkg::*;
#(
    parameter int         LDN_W   = 4,
    parameter logic [7:0] REV_VAL = 8'h03
) (
    input  port_acc_t         acc,
    input  logic [7:0]        index,
    input  logic [LDN_W-1:0]  ldn,
    input  logic              sel_act,
    input  logic [15:0]       sel_base,
    input  logic [7:0]        ext_rdata,
    output logic [7:0]        rdata
);

    logic [7:0] reg_val;

    always_comb begin
        reg_val = 8'h00;
        if (index >= IDX_EXT_MIN) begin
            reg_val = ext_rdata;
        end else begin
            case (index)
                IDX_LDN:     reg_val = {{(8-LDN_W){1'b0}}, ldn};
                IDX_CHIP_ID: reg_val = CHIP_ID_VAL;
                IDX_REV:     reg_val = REV_VAL;
                IDX_ACT:     reg_val = {7'b0, sel_act};
                IDX_BASE_HI: reg_val = sel_base[15:8];
                IDX_BASE_LO: reg_val = sel_base[7:0];
                default:     reg_val = 8'h00;
            endcase
        end

        rdata = 8'h00;
        if (acc.idx_rd)      rdata = index;
        else if (acc.dat_rd) rdata = reg_val;
    end

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfg_port_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                NUM_DEV  = 15,
    parameter logic [ADDR_W-1:0] BASE_PRI = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_ALT = 16'h004E,
    parameter logic [7:0]        REV_VAL  = 8'h03
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strap_alt,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic [NUM_DEV-1:0]    dev_active,
    output logic [NUM_DEV*16-1:0] dev_base,
    output logic                  ext_stb,
    output logic                  ext_we,
    output logic [$clog2(NUM_DEV)-1:0] ext_dev,
    output logic [7:0]            ext_idx,
    output logic [7:0]            ext_wdata,
    input  logic [7:0]            ext_rdata
);

    localparam int         LDN_W     = $clog2(NUM_DEV);
    localparam logic [7:0] LDN_LIMIT = 8'(NUM_DEV);

    typedef struct packed {
        logic [7:0]       index;
        logic [LDN_W-1:0] ldn;
    } ctl_t;

    ctl_t      ctl_d;
    ctl_t      ctl_q;
    port_acc_t acc;
    logic      wr_act;
    logic      wr_hi;
    logic      wr_lo;
    logic      sel_act;
    logic [15:0] sel_base;

    cfg_port_decode #(
        .ADDR_W   (ADDR_W),
        .BASE_PRI (BASE_PRI),
        .BASE_ALT (BASE_ALT)
    ) u_decode (
        .addr      (bus_addr),
        .strap_alt (strap_alt),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .acc       (acc)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (acc.idx_wr)
            ctl_d.index = bus_wdata;
        if (acc.dat_wr && ctl_q.index == IDX_LDN && bus_wdata < LDN_LIMIT)
            ctl_d.ldn = bus_wdata[LDN_W-1:0];

        wr_act = acc.dat_wr && (ctl_q.index == IDX_ACT);
        wr_hi  = acc.dat_wr && (ctl_q.index == IDX_BASE_HI);
        wr_lo  = acc.dat_wr && (ctl_q.index == IDX_BASE_LO);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    cfg_dev_bank #(
        .NUM_DEV (NUM_DEV),
        .LDN_W   (LDN_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (ctl_q.ldn),
        .wr_act   (wr_act),
        .wr_hi    (wr_hi),
        .wr_lo    (wr_lo),
        .wdata    (bus_wdata),
        .act      (dev_active),
        .base     (dev_base),
        .sel_act  (sel_act),
        .sel_base (sel_base)
    );

    cfg_read_mux #(
        .LDN_W   (LDN_W),
        .REV_VAL (REV_VAL)
    ) u_rmux (
        .acc       (acc),
        .index     (ctl_q.index),
        .ldn       (ctl_q.ldn),
        .sel_act   (sel_act),
        .sel_base  (sel_base),
        .ext_rdata (ext_rdata),
        .rdata     (bus_rdata)
    );

    // Forwarding of device-specific indices
    always_comb begin
        ext_stb   = (acc.dat_wr | acc.dat_rd) && (ctl_q.index >= IDX_EXT_MIN);
        ext_we    = acc.dat_wr;
        ext_dev   = ctl_q.ldn;
        ext_idx   = ctl_q.index;
        ext_wdata = bus_wdata;
    end

endmodule

// File: rtl/cfg_index_port_chk.sv
module cfg_index_port_chk #(
    parameter int ADDR_W  = 16,
    parameter int NUM_DEV = 15,
    parameter int LDN_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               strap_alt,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [7:0]         bus_wdata,
    input logic [7:0]         bus_rdata,
    input logic [NUM_DEV-1:0] dev_active,
    input logic               ext_stb,
    input logic [7:0]         index_q,
    input logic [LDN_W-1:0]   ldn_q
);

    localparam logic [7:0] NUM_DEV_B = 8'(NUM_DEV);

    logic [ADDR_W-1:0] exp_base;
    logic              at_idx;
    logic              at_dat;

    assign exp_base = strap_alt ? ADDR_W'(16'h004E) : ADDR_W'(16'h002E);
    assign at_idx   = (bus_addr == exp_base);
    assign at_dat   = (bus_addr == exp_base + ADDR_W'(1));

    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_idx && !at_dat) |-> (bus_rdata == 8'h00));

    p_idx_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_idx) |=> (index_q == $past(bus_wdata)));

    p_chip_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_dat && index_q == 8'h20) |-> (bus_rdata == 8'hE9));

    p_ldn_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_dat && index_q == 8'h07 && bus_wdata >= NUM_DEV_B)
        |=> $stable(ldn_q));

    p_ldn_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ({{(8-LDN_W){1'b0}}, ldn_q} < NUM_DEV_B));

    p_act_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && at_dat && index_q == 8'h30) |=> $stable(dev_active));

    p_stb_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_stb |-> ((bus_rd || bus_wr) && at_dat && index_q >= 8'hF0));

endmodule

bind cfg_index_port cfg_index_port_chk #(
    .ADDR_W  (ADDR_W),
    .NUM_DEV (NUM_DEV),
    .LDN_W   (LDN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_alt  (strap_alt),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .dev_active (dev_active),
    .ext_stb    (ext_stb),
    .index_q    (ctl_q.index),
    .ldn_q      (ctl_q.ldn)
);

// File: tb/test_cfg_index_port.sv
module test_cfg_index_port;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         strap_alt = 1'b0;
    logic [15:0]  bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic [14:0]  dev_active;
    logic [239:0] dev_base;
    logic         ext_stb;
    logic         ext_we;
    logic [3:0]   ext_dev;
    logic [7:0]   ext_idx;
    logic [7:0]   ext_wdata;
    logic [7:0]   ext_rdata = 8'h00;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cfg_index_port i_cfg_index_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_alt  (strap_alt),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .dev_active (dev_active),
        .dev_base   (dev_base),
        .ext_stb    (ext_stb),
        .ext_we     (ext_we),
        .ext_dev    (ext_dev),
        .ext_idx    (ext_idx),
        .ext_wdata  (ext_wdata),
        .ext_rdata  (ext_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Step encoding: {read, offset, data, expected, requirement number}
    localparam int NSTEP = 35;
    localparam logic [21:0] STEPS [NSTEP] = '{
        {1'b0, 1'b0, 8'h20, 8'h00, 4'd2},
        {1'b1, 1'b1, 8'h00, 8'hE9, 4'd3},   // R3 identifier
        {1'b0, 1'b1, 8'h55, 8'h00, 4'd3},
        {1'b1, 1'b1, 8'h00, 8'hE9, 4'd3},   // R3 write ignored
        {1'b0, 1'b0, 8'h27, 8'h00, 4'd2},
        {1'b1, 1'b1, 8'h00, 8'h03, 4'd4},   // R4 revision
        {1'b0, 1'b1, 8'hAA, 8'h00, 4'd4},
        {1'b1, 1'b1, 8'h00, 8'h03, 4'd4},   // R4 read-only
        {1'b0, 1'b0, 8'h07, 8'h00, 4'd2},
        {1'b0, 1'b1, 8'h05, 8'h00, 4'd5},
        {1'b1, 1'b1, 8'h00, 8'h05, 4'd5},   // R5 number reads back
        {1'b0, 1'b0, 8'h30, 8'h00, 4'd2},
        {1'b0, 1'b1, 8'hFF, 8'h00, 4'd6},
        {1'b1, 1'b1, 8'h00, 8'h01, 4'd6},   // R6 only bit 0 kept
        {1'b0, 1'b0, 8'h60, 8'h00, 4'd2},
        {1'b0, 1'b1, 8'h12, 8'h00, 4'd7},
        {1'b0, 1'b0, 8'h61, 8'h00, 4'd2},
        {1'b0, 1'b1, 8'h34, 8'h00, 4'd7},
        {1'b1, 1'b1, 8'h00, 8'h34, 4'd7},   // R7 low byte
        {1'b1, 1'b0, 8'h00, 8'h61, 4'd2},   // R2 index readback
        {1'b0, 1'b0, 8'h60, 8'h00, 4'd2},
        {1'b1, 1'b1, 8'h00, 8'h12, 4'd7},   // R7 high byte
        {1'b0, 1'b0, 8'h2A, 8'h00, 4'd2},
        {1'b1, 1'b1, 8'h00, 8'h00, 4'd10},  // R10 unimplemented read
        {1'b0, 1'b1, 8'h77, 8'h00, 4'd10},
        {1'b1, 1'b1, 8'h00, 8'h00, 4'd10},  // R10 write had no effect
        {1'b0, 1'b0, 8'h07, 8'h00, 4'd2},
        {1'b0, 1'b1, 8'h0F, 8'h00, 4'd5},
        {1'b1, 1'b1, 8'h00, 8'h05, 4'd5},   // R5 out-of-range ignored
        {1'b0, 1'b1, 8'h0E, 8'h00, 4'd5},
        {1'b1, 1'b1, 8'h00, 8'h0E, 4'd5},   // R5 top value accepted
        {1'b0, 1'b0, 8'h30, 8'h00, 4'd2},
        {1'b1, 1'b1, 8'h00, 8'h00, 4'd6},   // R6 other bank untouched
        {1'b0, 1'b0, 8'h60, 8'h00, 4'd2},
        {1'b1, 1'b1, 8'h00, 8'h00, 4'd7}    // R7 other bank untouched
    };

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            summary();
        end
    end

    initial begin
        logic [7:0] rv;
        logic [21:0] s;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        check(dev_active == '0, "R11 active", 256'(dev_active), 0);
        check(dev_base == '0, "R11 base", 256'(dev_base), 0);
        check(ext_stb == 1'b0, "R9 idle strobe", 256'(ext_stb), 0);
        bus_read(16'h002E, rv);
        check(rv == 8'h00, "R11 index", 256'(rv), 0);
        bus_write(16'h002E, 8'h07);
        bus_read(16'h002F, rv);
        check(rv == 8'h00, "R11 ldn", 256'(rv), 0);
        check(bus_rdata == 8'h00, "R1 idle rdata", 256'(bus_rdata), 0);

        // Stimulus table at base 0x2E
        for (int i = 0; i < NSTEP; i++) begin
            s = STEPS[i];
            if (s[21]) begin
                bus_read(16'h002E + 16'(s[20]), rv);
                checks++;
                if (rv != s[11:4]) begin
                    errors++;
                    $display("FAIL R%0d step %0d: actual 0x%0h expected 0x%0h",
                             s[3:0], i, rv, s[11:4]);
                end
            end else begin
                bus_write(16'h002E + 16'(s[20]), s[19:12]);
            end
        end

        // R8 outputs follow banks
        check(dev_active == 15'h0020, "R8 active", 256'(dev_active), 256'h20);
        check(dev_base[5*16 +: 16] == 16'h1234, "R8 base dev5",
              256'(dev_base[5*16 +: 16]), 256'h1234);
        check((dev_base & ~({224'b0, 16'hFFFF} << 80)) == '0, "R8 other bases",
              256'(dev_base), 256'h1234 << 80);

        // R9 forwarded read
        bus_write(16'h002E, 8'hF1);
        ext_rdata = 8'hA5;
        @(negedge clk);
        bus_addr = 16'h002F; bus_rd = 1'b1;
        #1;
        check(bus_rdata == 8'hA5, "R9 read data", 256'(bus_rdata), 256'hA5);
        check(ext_stb && !ext_we && ext_idx == 8'hF1 && ext_dev == 4'hE,
              "R9 read strobe", 256'({ext_stb, ext_we, ext_idx, ext_dev}),
              256'({1'b1, 1'b0, 8'hF1, 4'hE}));
        @(negedge clk);
        bus_rd = 1'b0;
        #1 check(!ext_stb, "R9 strobe drops", 256'(ext_stb), 0);

        // R9 forwarded write
        @(negedge clk);
        bus_addr = 16'h002F; bus_wdata = 8'h3C; bus_wr = 1'b1;
        #1;
        check(ext_stb && ext_we && ext_wdata == 8'h3C, "R9 write strobe",
              256'({ext_stb, ext_we, ext_wdata}), 256'({1'b1, 1'b1, 8'h3C}));
        @(negedge clk);
        bus_wr = 1'b0;

        // R1 strap moves the port
        strap_alt = 1'b1;
        bus_read(16'h004E, rv);
        check(rv == 8'hF1, "R1 alt index", 256'(rv), 256'hF1);
        bus_write(16'h002E, 8'h20);
        bus_read(16'h002F, rv);
        check(rv == 8'h00, "R1 old base silent", 256'(rv), 0);
        bus_read(16'h004E, rv);
        check(rv == 8'hF1, "R1 old base no write", 256'(rv), 256'hF1);
        bus_write(16'h004E, 8'h20);
        bus_read(16'h004F, rv);
        check(rv == 8'hE9, "R1 alt data", 256'(rv), 256'hE9);
        bus_read(16'h1234, rv);
        check(rv == 8'h00, "R1 foreign addr", 256'(rv), 0);

        done = 1'b1;
        summary();
    end

endmodule